// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side each run on their own clock. The clocks may be the same net or fully unrelated. Four active-low status outputs report the fill level. `full_n` and `afull_n` are updated in the write-clock domain. `empty_n` and `aempty_n` are updated in the read-clock domain. The almost-empty and almost-full thresholds come from two offset inputs, `ae_ofs` (n) and `af_ofs` (m). A separate threshold register bank drives these inputs, and that bank holds the reset default of 7.

A dual-purpose pin, `wen2_ld`, is sampled while reset is held. If it is high during reset, the block runs in two-enable mode and the pin is a second, active-high write enable. If it is low during reset, the block runs in offset-load mode. In that mode `wen1_n` together with a low `wen2_ld` produces the `ofs_wr` strobe for the threshold bank, and no FIFO write takes place. In both modes a FIFO word is stored only when `wen1_n` is low and `wen2_ld` is high.

Read data passes through a registered output stage. The output enable is modelled as a data-valid indication: while it is disabled, the bus reads as zero. `DEPTH` must be a power of two; the default is 256.

Top module: `dcfifo9_prog`

## Requirements
- R1: After reset, `empty_n` and `aempty_n` are 0, `full_n` and `afull_n` are 1, and the output register holds all zeros.
- R2: On a rising `wr_clk` edge, a word is stored when `wen1_n`=0, `wen2_ld`=1 and `full_n`=1. With `wen2_ld`=0, no word is stored.
- R3: A write attempted while `full_n`=0 is discarded. The buffer contents and the order of the stored words stay unchanged.
- R4: A read takes place on a rising `rd_clk` edge only when both `rd_en1_n` and `rd_en2_n` are 0. If either is 1, the output register and the read position hold.
- R5: A read attempted while `empty_n`=0 is ignored, and the output register keeps its last value.
- R6: The level of `wen2_ld` during reset selects the mode: 1 selects two-enable mode, 0 selects offset-load mode. In offset-load mode, `wen1_n`=0 with `wen2_ld`=0 drives `ofs_wr` high and stores no word. In two-enable mode, `ofs_wr` stays 0.
- R7: `full_n` is 0 exactly when the write-side count equals DEPTH. `afull_n` is 0 when that count is at least DEPTH−m. With no reads, both flags change on the edge of the DEPTH-th write and of the (DEPTH−m)-th write respectively.
- R8: `empty_n` is 0 when the read-side count is 0. `aempty_n` is 0 when that count is at most n. A read updates both flags on the same read edge that loads the word.
- R9: When `oe_n`=1, `dout` is all zeros and `dout_en` is 0. When `oe_n`=0, `dout` carries the output register and `dout_en` is 1.
- R10: Under unrelated clocks, every accepted word is read out once, in order. Pointers cross the clock domains one bit per step. Flags may clear late, but never early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, applied to both domains |
| din | input | DW | Write data |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable (active high) or offset-load strobe (active low), chosen at reset |
| rd_en1_n | input | 1 | Read enable 1, active low |
| rd_en2_n | input | 1 | Read enable 2, active low |
| oe_n | input | 1 | Output enable, active low |
| ae_ofs | input | log2(DEPTH) | Almost-empty offset n |
| af_ofs | input | log2(DEPTH) | Almost-full offset m |
| dout | output | DW | Registered read data, zero while disabled |
| dout_en | output | 1 | High while `dout` is being driven |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| ofs_wr | output | 1 | Offset-register write strobe for the threshold bank |

## Verification
The properties assume the following about the inputs:
- Enables and data change away from the clock edge of their own domain.
- Reset is held for several cycles of both clocks.
- The offset inputs change only while the buffer is idle, so that a threshold never moves under a pointer that is in flight.

The stimulus drives every input at the falling edge of the clock that samples it. It sets the offsets only before a reset, and it holds reset for four read-clock cycles. It samples flags that depend on the other domain only after a settling wait of several cycles in each domain.

// File: rtl/dcfifo9_pkg.sv
package dcfifo9_pkg;

  // Function of the dual-purpose pin, latched while reset is held
  typedef enum logic {
    MODE_LOAD   = 1'b0,
    MODE_TWO_WE = 1'b1
  } pin_mode_e;

endpackage

// File: rtl/dcfifo9_rst_sync.sv
module dcfifo9_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/dcfifo9_ptr_sync.sv
module dcfifo9_ptr_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/dcfifo9_wr_ctrl.sv
module dcfifo9_wr_ctrl
  import dcfifo9_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wr_clk,
  input  logic          wrst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [AW-1:0] af_ofs,
  input  logic [PW-1:0] rgray_s,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          afull_n,
  output logic          ofs_wr
);

  pin_mode_e     mode_q, mode_d;
  logic [PW-1:0] wbin_q, wbin_d;
  logic [PW-1:0] wgray_q, wgray_d;
  logic [PW-1:0] rbin_s, level_d, af_thr;
  logic          full_n_q, full_n_d;
  logic          afull_n_q, afull_n_d;

  // Gray to binary: bit i is the parity of gray bits i and above
  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  always_comb begin
    mode_d    = wrst_n ? mode_q : pin_mode_e'(wen2_ld);
    wr_fire   = wrst_n && !wen1_n && wen2_ld && full_n_q;
    wbin_d    = wbin_q + PW'(wr_fire);
    wgray_d   = wbin_d ^ (wbin_d >> 1);
    level_d   = wbin_d - rbin_s;
    af_thr    = PW'(DEPTH) - {1'b0, af_ofs};
    full_n_d  = (level_d != PW'(DEPTH));
    afull_n_d = (level_d < af_thr);
    ofs_wr    = wrst_n && (mode_q == MODE_LOAD) && !wen1_n && !wen2_ld;
  end

  // Mode latch: follows the pin while reset is held, frozen afterwards
  always_ff @(posedge wr_clk) begin
    mode_q <= mode_d;
  end

  always_ff @(posedge wr_clk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q    <= '0;
      wgray_q   <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
    end else begin
      if (wr_fire) begin
        wbin_q  <= wbin_d;
        wgray_q <= wgray_d;
      end
      full_n_q  <= full_n_d;
      afull_n_q <= afull_n_d;
    end
  end

  assign waddr   = wbin_q[AW-1:0];
  assign wptr    = wbin_q;
  assign wgray   = wgray_q;
  assign full_n  = full_n_q;
  assign afull_n = afull_n_q;

endmodule

// File: rtl/dcfifo9_rd_ctrl.sv
module dcfifo9_rd_ctrl #(
  parameter  int DEPTH = 256,
  parameter  int DW    = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          rd_clk,
  input  logic          rrst_n,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  input  logic [AW-1:0] ae_ofs,
  input  logic [PW-1:0] wgray_s,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] rdata_q,
  output logic          empty_n,
  output logic          aempty_n
);

  logic          rd_fire;
  logic [PW-1:0] rbin_q, rbin_d;
  logic [PW-1:0] rgray_q, rgray_d;
  logic [PW-1:0] wbin_s, level_d;
  logic [DW-1:0] rdata_d;
  logic          empty_n_q, empty_n_d;
  logic          aempty_n_q, aempty_n_d;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  always_comb begin
    rd_fire    = rrst_n && !rd_en1_n && !rd_en2_n && empty_n_q;
    rbin_d     = rbin_q + PW'(rd_fire);
    rgray_d    = rbin_d ^ (rbin_d >> 1);
    level_d    = wbin_s - rbin_d;
    empty_n_d  = (level_d != '0);
    aempty_n_d = (level_d > {1'b0, ae_ofs});
    rdata_d    = rd_fire ? rd_word : rdata_q;
  end

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      rdata_q    <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      if (rd_fire) begin
        rbin_q  <= rbin_d;
        rgray_q <= rgray_d;
      end
      rdata_q    <= rdata_d;
      empty_n_q  <= empty_n_d;
      aempty_n_q <= aempty_n_d;
    end
  end

  assign raddr    = rbin_q[AW-1:0];
  assign rptr     = rbin_q;
  assign rgray    = rgray_q;
  assign empty_n  = empty_n_q;
  assign aempty_n = aempty_n_q;

endmodule

// File: rtl/dcfifo9_prog.sv
module dcfifo9_prog #(
  parameter  int DEPTH = 256,
  parameter  int DW    = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  input  logic          oe_n,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW-1:0] af_ofs,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          full_n,
  output logic          afull_n,
  output logic          ofs_wr
);

  logic          wrst_n, rrst_n;
  logic          wr_fire;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wptr, rptr, wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] rdata_q, rd_word;
  logic [DW-1:0] mem [DEPTH];

  dcfifo9_rst_sync i_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  dcfifo9_rst_sync i_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  dcfifo9_ptr_sync #(.W(PW)) i_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  dcfifo9_ptr_sync #(.W(PW)) i_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  dcfifo9_wr_ctrl #(.DEPTH(DEPTH)) i_wr (
    .wr_clk(wr_clk), .wrst_n(wrst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .af_ofs(af_ofs), .rgray_s(rgray_s), .wr_fire(wr_fire), .waddr(waddr),
    .wptr(wptr), .wgray(wgray), .full_n(full_n), .afull_n(afull_n), .ofs_wr(ofs_wr)
  );

  dcfifo9_rd_ctrl #(.DEPTH(DEPTH), .DW(DW)) i_rd (
    .rd_clk(rd_clk), .rrst_n(rrst_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .ae_ofs(ae_ofs), .wgray_s(wgray_s), .rd_word(rd_word), .raddr(raddr),
    .rptr(rptr), .rgray(rgray), .rdata_q(rdata_q), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  // Storage array: written in the write domain, read through the output register
  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[waddr] <= din;
  end

  assign rd_word = mem[raddr];
  assign dout_en = !oe_n;
  assign dout    = oe_n ? '0 : rdata_q;

endmodule

// File: rtl/dcfifo9_prog_chk.sv
module dcfifo9_prog_chk #(
  parameter int PW = 9,
  parameter int DW = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wen1_n,
  input logic          wen2_ld,
  input logic          rd_en1_n,
  input logic          rd_en2_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [DW-1:0] rdata_q
);

  assert_wen_hold_R2: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wen1_n || !wen2_ld) |=> $stable(wptr));

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    !full_n |=> $stable(wptr));

  assert_ren_hold_R4: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (rd_en1_n || rd_en2_n) |=> ($stable(rptr) && $stable(rdata_q)));

  assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    !empty_n |=> ($stable(rptr) && $stable(rdata_q)));

  assert_full_in_afull_R7: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    !full_n |-> !afull_n);

  assert_empty_in_aempty_R8: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    !empty_n |-> !aempty_n);

  assert_wgray_step_R10: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R10: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind dcfifo9_prog dcfifo9_prog_chk #(.PW(PW), .DW(DW)) i_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wen1_n(wen1_n), .wen2_ld(wen2_ld), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .wptr(wptr), .rptr(rptr), .wgray(wgray), .rgray(rgray), .rdata_q(rdata_q)
);

// File: tb/test_dcfifo9_prog.sv
module test_dcfifo9_prog;

  localparam int D  = 16;
  localparam int AW = 4;
  localparam int NSTREAM = 300;

  logic          wr_clk, rd_clk, rst_n;
  logic [8:0]    din;
  logic          wen1_n, wen2_ld, rd_en1_n, rd_en2_n, oe_n;
  logic [AW-1:0] ae_ofs, af_ofs;
  logic [8:0]    dout;
  logic          dout_en, empty_n, aempty_n, full_n, afull_n, ofs_wr;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q [D];

  dcfifo9_prog #(.DEPTH(D), .DW(9)) i_dcfifo9_prog (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
    .wen1_n(wen1_n), .wen2_ld(wen2_ld), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .oe_n(oe_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(dout), .dout_en(dout_en),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n),
    .ofs_wr(ofs_wr)
  );

  initial begin wr_clk = 1'b0; forever #5 wr_clk = ~wr_clk; end
  initial begin rd_clk = 1'b0; forever #6.5 rd_clk = ~rd_clk; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pin);
    @(negedge wr_clk);
    rst_n = 1'b0; wen2_ld = pin; wen1_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    wen2_ld = 1'b1;
    @(negedge wr_clk);
  endtask

  task automatic push(input logic [8:0] d);
    @(negedge wr_clk); din = d; wen1_n = 1'b0;
    @(negedge wr_clk); wen1_n = 1'b1;
  endtask

  task automatic pop();
    @(negedge rd_clk); rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rd_clk); rd_en1_n = 1'b1; rd_en2_n = 1'b1;
  endtask

  task automatic settle();
    repeat (5) @(negedge rd_clk);
    repeat (5) @(negedge wr_clk);
  endtask

  task automatic sweep(input int m, input int n);
    af_ofs = AW'(m); ae_ofs = AW'(n);
    do_reset(1'b1);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 aempty_n", aempty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 afull_n", afull_n, 1);
    chk("R1 dout", dout, 0);
    for (int k = 1; k <= D; k++) begin
      exp_q[k-1] = 9'((k * 37 + m * 5 + n) % 512);
      push(exp_q[k-1]);
      chk("R7 full_n", full_n, (k != D));
      chk("R7 afull_n", afull_n, (k < D - m));
      settle();
      chk("R8 empty_n", empty_n, 1);
      chk("R8 aempty_n", aempty_n, (k > n));
    end
    push(9'h1FF);               // R3: write while full is dropped
    settle();
    chk("R3 full_n", full_n, 0);
    for (int k = D; k >= 1; k--) begin
      pop();
      chk("R3 R4 dout", dout, exp_q[D-k]);
      chk("R8 empty_n", empty_n, (k - 1 != 0));
      chk("R8 aempty_n", aempty_n, (k - 1 > n));
    end
    pop();                      // R5: read while empty is ignored
    chk("R5 dout", dout, exp_q[D-1]);
    settle();
    chk("R7 full_n", full_n, 1);
    chk("R7 afull_n", afull_n, 1);
  endtask

  initial begin
    int mv [3];
    int nv [3];
    mv = '{0, 3, 15};
    nv = '{0, 7, 15};
    rst_n = 1'b0; din = '0; wen1_n = 1'b1; wen2_ld = 1'b1;
    rd_en1_n = 1'b1; rd_en2_n = 1'b1; oe_n = 1'b0;
    ae_ofs = AW'(7); af_ofs = AW'(7);

    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) sweep(mv[i], nv[j]);

    // Two-enable mode: low second enable blocks the write, no offset strobe
    af_ofs = AW'(3); ae_ofs = AW'(2);
    do_reset(1'b1);
    @(negedge wr_clk); din = 9'h0F0; wen1_n = 1'b0; wen2_ld = 1'b0;
    #1 chk("R6 ofs_wr two-enable", ofs_wr, 0);
    @(negedge wr_clk); wen1_n = 1'b1; wen2_ld = 1'b1;
    settle();
    chk("R2 empty_n after blocked write", empty_n, 0);

    // One read enable high holds the output register
    push(9'h055); push(9'h0AA);
    settle();
    pop();
    chk("R4 first word", dout, 9'h055);
    @(negedge rd_clk); rd_en1_n = 1'b0; rd_en2_n = 1'b1;
    @(negedge rd_clk); rd_en1_n = 1'b1;
    chk("R4 hold en2 high", dout, 9'h055);
    @(negedge rd_clk); rd_en1_n = 1'b1; rd_en2_n = 1'b0;
    @(negedge rd_clk); rd_en2_n = 1'b1;
    chk("R4 hold en1 high", dout, 9'h055);
    chk("R4 still data", empty_n, 1);
    pop();
    chk("R4 second word", dout, 9'h0AA);

    // Output enable
    oe_n = 1'b1;
    #1 chk("R9 dout disabled", dout, 0);
    chk("R9 dout_en disabled", dout_en, 0);
    oe_n = 1'b0;
    #1 chk("R9 dout enabled", dout, 9'h0AA);
    chk("R9 dout_en enabled", dout_en, 1);

    // Offset-load mode
    do_reset(1'b0);
    @(negedge wr_clk); din = 9'h011; wen1_n = 1'b0; wen2_ld = 1'b0;
    #1 chk("R6 ofs_wr load mode", ofs_wr, 1);
    @(negedge wr_clk); wen1_n = 1'b1; wen2_ld = 1'b1;
    #1 chk("R6 ofs_wr idle", ofs_wr, 0);
    settle();
    chk("R6 no fifo write on load", empty_n, 0);
    push(9'h123);
    settle();
    chk("R2 write in load mode", empty_n, 1);
    pop();
    chk("R2 data in load mode", dout, 9'h123);

    // Streaming with unrelated clocks
    do_reset(1'b1);
    fork
      begin : writer
        int sent = 0;
        while (sent < NSTREAM) begin
          @(negedge wr_clk);
          if (full_n && (sent % 5 != 3 || wen1_n == 1'b0)) begin
            din = 9'(sent) ^ 9'h0A5; wen1_n = 1'b0; sent++;
          end else begin
            wen1_n = 1'b1;
            if (sent % 5 == 3 && full_n) begin
              @(negedge wr_clk);
              din = 9'(sent) ^ 9'h0A5; wen1_n = 1'b0; sent++;
            end
          end
        end
        @(negedge wr_clk); wen1_n = 1'b1;
      end
      begin : reader
        int got = 0;
        int cyc = 0;
        logic pend = 1'b0;
        while (got < NSTREAM) begin
          @(negedge rd_clk);
          cyc++;
          if (pend) begin
            chk("R10 stream order", dout, 9'(got) ^ 9'h0A5);
            got++;
          end
          if (empty_n && (cyc % 7 != 2) && got + 32'(pend) < NSTREAM) begin
            rd_en1_n = 1'b0; rd_en2_n = 1'b0; pend = 1'b1;
          end else begin
            rd_en1_n = 1'b1; rd_en2_n = 1'b1; pend = 1'b0;
          end
        end
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
      end
    join
    settle();
    chk("R10 drained empty", empty_n, 0);
    chk("R10 drained not full", full_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL R10 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule